// File: doc/BRIEF.md
# Real-time counter with compare channels

This block is a free-running time base for low-power operation. A slow tick enable, nominally 32.768 kHz, goes through a programmable divider and drives a 24-bit up-counter. Four compare channels watch the counter. Each one raises its own latched flag on the step where the counter reaches its stored value. The counter also latches a flag for every step, and another one when it wraps from 0xFFFFFF to zero.

Software controls the block through a word-addressed register bus. Write-only command registers start, stop, clear, and preload the counter. Two enable masks have their own set and clear aliases. One mask gates the single interrupt output. The other gates one-cycle event pulses, and it is independent of the first.

A compare value placed two or more steps ahead of the current count always fires. This is the lead time that software must respect when it arms a channel.

Top module: `rtc_counter`

## Requirements
- R1: After reset the counter, divider setting, all flags and both enable masks read zero, the counter is stopped and `irq` is low.
- R2: Command word addresses are start=0, stop=1, clear=2, preload=3. A command acts only when write-data bit 0 is 1. Start lets ticks advance the counter and stop freezes it. Ticks while stopped change nothing.
- R3: The divider setting P is at word address 10, 12 bits wide. The counter advances once per P+1 ticks. The counter reads at word address 9 in bits [23:0], with bits [31:24] zero.
- R4: A write to the divider setting while the counter runs is ignored, so the old value reads back. A write while the counter is stopped is accepted and restarts the divider phase.
- R5: The clear command sets the counter to zero and restarts the divider phase.
- R6: The preload command loads 0xFFFFF0. The step from 0xFFFFFF goes to 0 and sets the wrap flag.
- R7: The step flag is set on every counter advance.
- R8: Compare values sit at word addresses 24+i for channel i, in bits [23:0]. The flag of channel i is set on the step where the counter becomes equal to its value. A value two or more steps ahead always fires, and the flag stays clear before that step.
- R9: Flags read in bit 0 at word addresses 16 (step), 17 (wrap) and 18+i (compare i). Writing 0 to bit 0 clears a flag. Writing 1 leaves it unchanged.
- R10: The interrupt mask uses bit 0 for step, bit 1 for wrap and bit 16+i for compare i. Word address 4 ORs written ones into the mask and address 5 removes them. Both addresses read back the mask.
- R11: The event mask has the same layout. Address 6 writes it directly, 7 sets bits and 8 clears them, and all three read it back. Changing it does not touch the interrupt mask. `evt_out` bit 0 (step), bit 1 (wrap) or bit 2+i (compare i) pulses for one cycle, in the cycle after an enabled event.
- R12: `irq` is high exactly when some flag is set and its interrupt mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle slow tick enable |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |
| evt_out | output | 6 | One-cycle event pulses gated by the event mask |

## Verification
The bench builds the block with its defaults: a 24-bit counter, a 12-bit divider field, four channels and a preload lead of 16. With the lead of 16, the preload command brings the 0xFFFFFF wrap within sixteen steps. Random divider settings of 0 to 3 cover both undivided and divided stepping in a short run. Compare values are aimed at exactly two steps ahead and at values that fall just before and just after the wrap.

// File: rtl/rtc_pkg.sv
// Shared register addresses and event indices for the real-time counter.
// Assumes a word-addressed bus of at least 5 address bits.
package rtc_pkg;
    localparam int A_START   = 0;
    localparam int A_STOP    = 1;
    localparam int A_CLEAR   = 2;
    localparam int A_PRELOAD = 3;
    localparam int A_IEN_SET = 4;
    localparam int A_IEN_CLR = 5;
    localparam int A_EEN     = 6;
    localparam int A_EEN_SET = 7;
    localparam int A_EEN_CLR = 8;
    localparam int A_COUNT   = 9;
    localparam int A_DIV     = 10;
    localparam int A_EV_BASE = 16;
    localparam int A_CC_BASE = 24;
    // internal event vector index
    localparam int EV_STEP   = 0;
    localparam int EV_WRAP   = 1;
    localparam int EV_CMP0   = 2;
    // bus bit of compare channel 0 in the mask registers
    localparam int BIT_CMP0  = 16;
endpackage

// File: rtl/rtc_prescaler.sv
// Tick divider: passes one of every div+1 tick enables as a counter step.
// Assumes restart is raised whenever div changes, so the phase stays <= div.
module rtc_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick_en,
    input  logic             restart,
    input  logic [PRE_W-1:0] div,
    output logic             step
);
    logic [PRE_W-1:0] phase;

    // a step is the last tick of a phase, suppressed by a restart
    assign step = run & tick_en & ~restart & (phase == div);

    // phase counter advances on every tick while running
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            phase <= '0;
        else if (run && tick_en)
            phase <= (phase == div) ? '0 : phase + 1'b1;
    end

    // R3
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (phase == '0));
    // R3
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= div);
endmodule

// File: rtl/rtc_cmp_chan.sv
// One compare channel: holds a value and flags a step that lands on it.
// Assumes cnt_nxt is the counter value that the current step produces.
module rtc_cmp_chan #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wval,
    input  logic             step,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic [CNT_W-1:0] cc,
    output logic             hit
);
    // compare value register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cc <= '0;
        else if (wr)
            cc <= wval;
    end

    // match only when a step makes the counter equal to the value
    assign hit = step && (cnt_nxt == cc);

    // R8
    cc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cc == $past(wval)));
endmodule

// File: rtl/rtc_counter.sv
// Real-time counter top: register decode, counter, flags, masks and interrupt.
// Assumes one bus access per cycle, NCMP <= 6 and CNT_W < DW.
module rtc_counter
    import rtc_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int PRE_W     = 12,
    parameter int NCMP      = 4,
    parameter int TRIG_LEAD = 16,
    parameter int AW        = 5,
    parameter int DW        = 32,
    localparam int NEV      = NCMP + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic [NEV-1:0] evt_out
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] PRELOAD  = CNT_MAX - CNT_W'(TRIG_LEAD - 1);

    function automatic logic at(input logic [AW-1:0] ad, input int a);
        return ad == AW'(a);
    endfunction

    function automatic logic [DW-1:0] spread(input logic [NEV-1:0] m);
        logic [DW-1:0] w;
        w = '0;
        w[EV_STEP] = m[EV_STEP];
        w[EV_WRAP] = m[EV_WRAP];
        for (int i = 0; i < NCMP; i++) w[BIT_CMP0 + i] = m[EV_CMP0 + i];
        return w;
    endfunction

    logic             wr_any, go, halt, clr, trig, div_wr, step;
    logic             run;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [PRE_W-1:0] div;
    logic [NEV-1:0]   flg, ien, een, ev_raw, wmask;
    logic [NCMP-1:0]  hit;
    logic [CNT_W-1:0] cc [NCMP];
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DW-1:CNT_W];

    // command and write decode
    assign wr_any = bus_sel & bus_we;
    assign go     = wr_any & at(bus_addr, A_START)   & bus_wdata[0];
    assign halt   = wr_any & at(bus_addr, A_STOP)    & bus_wdata[0];
    assign clr    = wr_any & at(bus_addr, A_CLEAR)   & bus_wdata[0];
    assign trig   = wr_any & at(bus_addr, A_PRELOAD) & bus_wdata[0];
    assign div_wr = wr_any & at(bus_addr, A_DIV)     & ~run;

    // bus word to internal mask layout
    always_comb begin
        wmask[EV_STEP] = bus_wdata[0];
        wmask[EV_WRAP] = bus_wdata[1];
        for (int i = 0; i < NCMP; i++) wmask[EV_CMP0 + i] = bus_wdata[BIT_CMP0 + i];
    end

    // run state from start/stop commands
    always_ff @(posedge clk) begin
        if (!rst_n)    run <= 1'b0;
        else if (go)   run <= 1'b1;
        else if (halt) run <= 1'b0;
    end

    // divider setting, writable only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)      div <= '0;
        else if (div_wr) div <= bus_wdata[PRE_W-1:0];
    end

    rtc_prescaler #(.PRE_W(PRE_W)) i_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .tick_en(tick_en),
        .restart(clr | trig | div_wr), .div(div), .step(step)
    );

    // main counter: commands take priority over a step
    assign cnt_nxt = cnt + 1'b1;
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (trig)     cnt <= PRELOAD;
        else if (step)     cnt <= cnt_nxt;
    end

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr && !trig) |=> $stable(cnt));
    // R4
    div_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_any && at(bus_addr, A_DIV)) |=> $stable(div));

    for (genvar i = 0; i < NCMP; i++) begin : g_chan
        rtc_cmp_chan #(.CNT_W(CNT_W)) i_chan (
            .clk(clk), .rst_n(rst_n),
            .wr(wr_any & at(bus_addr, A_CC_BASE + i)),
            .wval(bus_wdata[CNT_W-1:0]), .step(step), .cnt_nxt(cnt_nxt),
            .cc(cc[i]), .hit(hit[i])
        );
        assign ev_raw[EV_CMP0 + i] = hit[i];
    end

    assign ev_raw[EV_STEP] = step;
    assign ev_raw[EV_WRAP] = step && (cnt == CNT_MAX);

    // R6
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == CNT_MAX) |=> (cnt == '0 && flg[EV_WRAP]));

    for (genvar k = 0; k < NEV; k++) begin : g_flag
        // latched flag: hardware set wins over a software clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                flg[k] <= 1'b0;
            else if (ev_raw[k])
                flg[k] <= 1'b1;
            else if (wr_any && at(bus_addr, A_EV_BASE + k) && !bus_wdata[0])
                flg[k] <= 1'b0;
        end
    end

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp_chk
        // R8
        cmp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> (flg[EV_CMP0 + i] && cnt == $past(cc[i])));
    end

    // interrupt mask with set and clear aliases
    always_ff @(posedge clk) begin
        if (!rst_n)                                ien <= '0;
        else if (wr_any && at(bus_addr, A_IEN_SET)) ien <= ien | wmask;
        else if (wr_any && at(bus_addr, A_IEN_CLR)) ien <= ien & ~wmask;
    end

    // event mask with direct, set and clear writes
    always_ff @(posedge clk) begin
        if (!rst_n)                                een <= '0;
        else if (wr_any && at(bus_addr, A_EEN))     een <= wmask;
        else if (wr_any && at(bus_addr, A_EEN_SET)) een <= een | wmask;
        else if (wr_any && at(bus_addr, A_EEN_CLR)) een <= een & ~wmask;
    end

    // one-cycle event pulses gated by the event mask
    always_ff @(posedge clk) begin
        if (!rst_n) evt_out <= '0;
        else        evt_out <= ev_raw & een;
    end

    assign irq = |(flg & ien);

    // register read mux
    always_comb begin
        bus_rdata = '0;
        if (at(bus_addr, A_IEN_SET) || at(bus_addr, A_IEN_CLR))
            bus_rdata = spread(ien);
        if (at(bus_addr, A_EEN) || at(bus_addr, A_EEN_SET) || at(bus_addr, A_EEN_CLR))
            bus_rdata = spread(een);
        if (at(bus_addr, A_COUNT))
            bus_rdata = DW'(cnt);
        if (at(bus_addr, A_DIV))
            bus_rdata = DW'(div);
        for (int k = 0; k < NEV; k++)
            if (at(bus_addr, A_EV_BASE + k)) bus_rdata = DW'(flg[k]);
        for (int i = 0; i < NCMP; i++)
            if (at(bus_addr, A_CC_BASE + i)) bus_rdata = DW'(cc[i]);
    end
endmodule

// File: tb/test_rtc_counter.sv
`timescale 1ns/1ps
module test_rtc_counter;
    logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq;
    logic [5:0]  evt_out;

    rtc_counter i_rtc_counter (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .evt_out(evt_out)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [23:0] m_cnt;
    int          m_pc, m_p;
    bit          m_run;
    logic [5:0]  m_flg, m_ien, m_een, m_evt, last_evt;
    logic [23:0] m_cc [4];

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [5:0] pk(logic [31:0] d);
        return {d[19:16], d[1], d[0]};
    endfunction

    function automatic logic [31:0] sp(logic [5:0] m);
        return {12'b0, m[5:2], 14'b0, m[1:0]};
    endfunction

    task automatic bwr(int a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic brd(int a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = 5'(a);
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    // write plus reference-model update from the requirements
    task automatic wr(int a, logic [31:0] d);
        bwr(a, d);
        case (a)
            0: if (d[0]) m_run = 1;
            1: if (d[0]) m_run = 0;
            2: if (d[0]) begin m_cnt = 0; m_pc = 0; end
            3: if (d[0]) begin m_cnt = 24'hFFFFF0; m_pc = 0; end
            4: m_ien = m_ien | pk(d);
            5: m_ien = m_ien & ~pk(d);
            6: m_een = pk(d);
            7: m_een = m_een | pk(d);
            8: m_een = m_een & ~pk(d);
            10: if (!m_run) begin m_p = int'(d[11:0]); m_pc = 0; end
            16, 17, 18, 19, 20, 21: if (!d[0]) m_flg[a-16] = 0;
            24, 25, 26, 27: m_cc[a-24] = d[23:0];
            default: ;
        endcase
    endtask

    task automatic tick(int n);
        repeat (n) begin
            @(negedge clk) tick_en = 1;
            @(negedge clk) tick_en = 0;
            last_evt = evt_out;
            m_evt = 0;
            if (m_run) begin
                if (m_pc == m_p) begin
                    logic [5:0] ev;
                    m_pc = 0;
                    ev = 6'b1;
                    ev[1] = (m_cnt == 24'hFFFFFF);
                    m_cnt = m_cnt + 1;
                    for (int i = 0; i < 4; i++) ev[2+i] = (m_cnt == m_cc[i]);
                    m_flg = m_flg | ev;
                    m_evt = ev & m_een;
                end else m_pc++;
            end
            chk("R11 evt_out", 32'(last_evt), 32'(m_evt));
        end
    endtask

    task automatic chk_all(string tag);
        logic [31:0] d;
        brd(9, d);
        chk({tag, " R3 count"}, d, {8'b0, m_cnt});
        for (int k = 0; k < 6; k++) begin
            brd(16 + k, d);
            chk({tag, " R9 flag"}, d, 32'(m_flg[k]));
        end
        chk({tag, " R12 irq"}, 32'(irq), 32'(|(m_flg & m_ien)));
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        m_cnt = 0; m_pc = 0; m_p = 0; m_run = 0;
        m_flg = 0; m_ien = 0; m_een = 0; last_evt = 0; m_evt = 0;
        for (int i = 0; i < 4; i++) m_cc[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk_all("R1");
        brd(4, d);  chk("R1 ien", d, 0);
        brd(6, d);  chk("R1 een", d, 0);
        brd(10, d); chk("R1 div", d, 0);

        // R2 stopped, start with bit0=0, then start and stop
        tick(3); chk_all("R2 stopped");
        wr(0, 32'h2); tick(2); chk_all("R2 bit0 zero");
        wr(0, 1); tick(5); chk_all("R2 running");
        wr(1, 1); tick(3); chk_all("R2 halted");

        // R3 divider while stopped, R4 write ignored while running
        wr(10, 2); brd(10, d); chk("R3 div read", d, 2);
        wr(0, 1); tick(9); chk_all("R3 divided");
        wr(10, 5); brd(10, d); chk("R4 div locked", d, 2);

        // R5 clear restarts phase
        tick(1); wr(2, 1); chk_all("R5 cleared");
        tick(2); chk_all("R5 phase a");
        tick(1); chk_all("R5 phase b");

        // R6 preload and wrap; R10 mask with R12 irq
        wr(1, 1); wr(10, 0); wr(0, 1);
        wr(17, 0); wr(3, 1);
        brd(9, d); chk("R6 preload", d, 32'h00FFFFF0);
        tick(15); chk_all("R6 before wrap");
        tick(1); chk_all("R6 after wrap");
        brd(9, d); chk("R6 zero", d, 0);

        // R10 set/clear aliases
        wr(4, 32'h000F0003); brd(4, d); chk("R10 set", d, 32'h000F0003);
        wr(5, 32'h00050001); brd(5, d); chk("R10 clr", d, 32'h000A0002);
        chk("R12 irq wrap", 32'(irq), 32'(|(m_flg & m_ien)));
        wr(17, 0); chk("R12 irq low", 32'(irq), 32'(|(m_flg & m_ien)));

        // R7 step flag and R9 write semantics
        wr(16, 0); tick(1); chk_all("R7 step flag");
        wr(16, 1); brd(16, d); chk("R9 write one keeps", d, 1);
        wr(16, 0); brd(16, d); chk("R9 write zero clears", d, 0);

        // R8 compare exactly two steps ahead on every channel
        for (int i = 0; i < 4; i++) begin
            wr(18 + i, 0);
            wr(24 + i, {8'b0, m_cnt + 24'd2});
            tick(1); brd(18 + i, d); chk("R8 not yet", d, 0);
            tick(1); brd(18 + i, d); chk("R8 fired", d, 1);
        end

        // R11 event mask independent of interrupt mask
        wr(6, 32'h00010001); brd(8, d); chk("R11 een", d, 32'h00010001);
        brd(4, d); chk("R11 ien untouched", d, sp(m_ien));
        wr(24, {8'b0, m_cnt + 24'd1}); tick(2);
        wr(7, 32'h2); wr(8, 32'h1); brd(7, d); chk("R11 een set/clr", d, 32'h00010002);

        // random phase: divider, compares, ticks
        for (int it = 0; it < 30; it++) begin
            wr(1, 1);
            wr(10, $urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0) wr(3, 1);
            wr(0, 1);
            for (int i = 0; i < 4; i++)
                wr(24 + i, {8'b0, m_cnt + 24'($urandom_range(2, 10))});
            wr(4, $urandom & 32'h000F0003);
            wr(7, $urandom & 32'h000F0003);
            tick($urandom_range(0, 20));
            chk_all("R8 random");
            for (int k = 0; k < 6; k++) if ($urandom_range(0, 1) == 1) wr(16 + k, 0);
            wr(5, $urandom & 32'h000F0003);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule